// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This controller runs a very small instruction set by asking a separate bus-cycle engine to perform machine cycles one at a time. It holds a 16-bit program counter, an 8-bit accumulator, an 8-bit register C and a 16-bit store-address latch. Every instruction begins with an opcode fetch. The fetched opcode then decides what follows: nothing, one operand read, or two address-byte reads and a write. The number of cycles therefore depends on the opcode rather than on the instruction length. A three-byte store takes four cycles.

A request goes out on a valid/ready channel. `cyc_valid` stays high, with kind, address and write data held constant, until `cyc_ready` is sampled high. Once a request has been accepted, no new request is raised until the bus engine reports completion with a one-cycle `rsp_valid` pulse, which carries the read byte on `rsp_data`. A pulse on `rsp_valid` while no request is outstanding has no effect. The registers change on the clock edge that samples `rsp_valid`, and the next request is raised in the following cycle.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high and after it falls, `pc_o`, `acc_o` and `regc_o` read zero, and the first request is an opcode fetch from address 0000h.
- R2: `cyc_kind` uses 00 for opcode fetch, 01 for memory read and 10 for memory write, and never 11. Each instruction starts with an opcode fetch from the address in `pc_o`.
- R3: After opcode 3Eh, one memory read at `pc_o` follows, and its response byte is loaded into the accumulator.
- R4: After opcode 32h, a read of the low address byte follows, then a read of the high address byte, then a write of the accumulator to the address {high, low}. The write address never comes from the program counter.
- R5: Opcode 4Fh causes no further cycles. The accumulator is copied into register C on the fetch response.
- R6: Any other opcode causes no further cycles and changes no register except the program counter.
- R7: The program counter rises by exactly one on each fetch or read response. It does not change on a write response or at any other time.
- R8: While `cyc_valid` is high and `cyc_ready` is low, the request and its fields stay unchanged. After acceptance, `cyc_valid` stays low until `rsp_valid`. A `rsp_valid` pulse with no request outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | output | 1 | Machine-cycle request pending |
| cyc_ready | input | 1 | Bus engine accepts the pending request |
| cyc_kind | output | 2 | Cycle type: 00 fetch, 01 read, 10 write |
| cyc_addr | output | 16 | Cycle address |
| cyc_wdata | output | 8 | Byte to write (accumulator) |
| rsp_valid | input | 1 | One-cycle completion pulse for the accepted cycle |
| rsp_data | input | 8 | Byte read, valid with `rsp_valid` |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| regc_o | output | 8 | Register C |

## Verification
The hardest case to reach is a stray completion pulse that arrives while a request is still waiting for acceptance. To produce it, the bench stalls `cyc_ready` for a varying number of cycles and fires `rsp_valid` with junk data in the first stalled cycle. It then confirms that the request, the program counter and the accumulator all stay unchanged. The program mixes loads, copies, stores to a high address, to address zero and to an address whose high byte differs from its low byte, as well as undecoded opcodes. Response latency varies from cycle to cycle. A behavioural interpreter in the bench predicts every request and every register value.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_IMM,
    PH_ALO,
    PH_AHI,
    PH_STORE
  } phase_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [7:0] OP_LDI = 8'h3E,
  parameter logic [7:0] OP_STO = 8'h32,
  parameter logic [7:0] OP_CPY = 8'h4F
) (
  input  logic [DW-1:0] opcode,
  output phase_e        after_fetch,
  output logic          copy_en
);
  always_comb begin
    after_fetch = PH_FETCH;
    copy_en     = 1'b0;
    if (opcode == DW'(OP_LDI))      after_fetch = PH_IMM;
    else if (opcode == DW'(OP_STO)) after_fetch = PH_ALO;
    else if (opcode == DW'(OP_CPY)) copy_en = 1'b1;
  end
endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_inc,
  input  logic          ld_acc,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          cp_c,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] regc,
  output logic [AW-1:0] st_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      acc     <= '0;
      regc    <= '0;
      st_addr <= '0;
    end else begin
      if (pc_inc) pc <= pc + 1'b1;
      if (ld_acc) acc <= din;
      if (cp_c)   regc <= acc;
      if (ld_lo)  st_addr[DW-1:0]  <= din;
      if (ld_hi)  st_addr[AW-1:DW] <= din;
    end
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [7:0] OP_LDI = 8'h3E,
  parameter logic [7:0] OP_STO = 8'h32,
  parameter logic [7:0] OP_CPY = 8'h4F,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  output logic          cyc_valid,
  input  logic          cyc_ready,
  output logic [1:0]    cyc_kind,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] regc_o
);
  phase_e ph, ph_nxt, dec_nxt;
  logic   waiting, take, copy_en;
  logic   pc_inc, ld_acc, ld_lo, ld_hi, cp_c;
  logic [AW-1:0] st_addr;

  seq_decode #(.DW(DW), .OP_LDI(OP_LDI), .OP_STO(OP_STO), .OP_CPY(OP_CPY)) u_dec (
    .opcode(rsp_data), .after_fetch(dec_nxt), .copy_en(copy_en)
  );

  assign take = waiting && rsp_valid;

  always_comb begin
    case (ph)
      PH_FETCH: ph_nxt = dec_nxt;
      PH_ALO:   ph_nxt = PH_AHI;
      PH_AHI:   ph_nxt = PH_STORE;
      default:  ph_nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      ph      <= PH_FETCH;
    end else if (!waiting && cyc_ready) begin
      waiting <= 1'b1;
    end else if (take) begin
      waiting <= 1'b0;
      ph      <= ph_nxt;
    end
  end

  assign pc_inc = take && (ph != PH_STORE);
  assign ld_acc = take && (ph == PH_IMM);
  assign ld_lo  = take && (ph == PH_ALO);
  assign ld_hi  = take && (ph == PH_AHI);
  assign cp_c   = take && (ph == PH_FETCH) && copy_en;

  seq_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .pc_inc(pc_inc), .ld_acc(ld_acc), .ld_lo(ld_lo),
    .ld_hi(ld_hi), .cp_c(cp_c), .din(rsp_data), .pc(pc_o), .acc(acc_o),
    .regc(regc_o), .st_addr(st_addr)
  );

  always_comb begin
    cyc_valid = !waiting;
    cyc_wdata = acc_o;
    cyc_addr  = (ph == PH_STORE) ? st_addr : pc_o;
    case (ph)
      PH_FETCH: cyc_kind = CYC_FETCH;
      PH_STORE: cyc_kind = CYC_WRITE;
      default:  cyc_kind = CYC_READ;
    endcase
  end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc_valid,
  input logic          cyc_ready,
  input logic [1:0]    cyc_kind,
  input logic [AW-1:0] cyc_addr,
  input logic [DW-1:0] cyc_wdata,
  input logic          rsp_valid,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] regc_o
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (cyc_valid && cyc_ready) outstanding <= 1'b1;
    else if (rsp_valid) outstanding <= 1'b0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pc_o == '0 && acc_o == '0 && regc_o == '0)); // R1
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst) cyc_valid |-> cyc_kind != 2'b11); // R2
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst) (cyc_valid && cyc_kind == 2'b00) |-> cyc_addr == pc_o); // R2
  AST_ACC_CAUSE: assert property (@(posedge clk) disable iff (rst) (acc_o != $past(acc_o)) |-> $past(rsp_valid)); // R3
  AST_WDATA_ACC: assert property (@(posedge clk) disable iff (rst) (cyc_valid && cyc_kind == 2'b10) |-> cyc_wdata == acc_o); // R4
  AST_C_CAUSE: assert property (@(posedge clk) disable iff (rst) (regc_o != $past(regc_o)) |-> (regc_o == $past(acc_o) && $past(rsp_valid))); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + 1'b1 && $past(rsp_valid))); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_kind))); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) outstanding |-> !cyc_valid); // R8
endmodule

bind instr_sequencer seq_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
  .cyc_kind(cyc_kind), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
  .rsp_valid(rsp_valid), .pc_o(pc_o), .acc_o(acc_o), .regc_o(regc_o)
);

// File: tb/instr_sequencer_test.sv
module instr_sequencer_test;
  logic clk = 1'b0, rst = 1'b1;
  logic cyc_valid, cyc_ready = 1'b0, rsp_valid = 1'b0;
  logic [1:0] cyc_kind;
  logic [15:0] cyc_addr, pc_o;
  logic [7:0] cyc_wdata, rsp_data = 8'h00, acc_o, regc_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] mem [int];
  int m_pc = 0, m_a = 0, m_c = 0, m_lo = 0, m_hi = 0, m_ph = 0;

  always #2.5 clk = ~clk;

  instr_sequencer uut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_kind(cyc_kind), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pc_o(pc_o), .acc_o(acc_o),
    .regc_o(regc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [7:0] prog [20] = '{8'h3E, 8'h5A, 8'h4F, 8'h32, 8'h65, 8'h20, 8'h00,
      8'h3E, 8'hA5, 8'h32, 8'hFF, 8'h03, 8'h76, 8'h4F, 8'h3E, 8'h00, 8'h4F,
      8'h32, 8'h00, 8'h00};
    for (int i = 0; i < 20; i++) mem[i] = prog[i];
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pc", pc_o, 0);
    chk("R1 acc", acc_o, 0);
    chk("R1 regc", regc_o, 0);
    chk("R1 valid", cyc_valid, 1);
    chk("R1 kind", cyc_kind, 0);
    chk("R1 addr", cyc_addr, 0);
    for (int t = 0; t < 45; t++) begin
      int ek, ea, d;
      string tag;
      logic [1:0] k; logic [15:0] a; logic [7:0] w;
      while (!cyc_valid) @(negedge clk);
      k = cyc_kind; a = cyc_addr; w = cyc_wdata;
      ek = (m_ph == 0) ? 0 : (m_ph == 4) ? 2 : 1;
      ea = (m_ph == 4) ? (m_hi * 256 + m_lo) : m_pc;
      tag = (m_ph == 0) ? "R2" : (m_ph == 1) ? "R3" : "R4";
      chk({tag, " kind"}, k, ek);
      chk({tag, " addr"}, a, ea);
      if (m_ph == 4) chk("R4 wdata", w, m_a);
      for (int h = 0; h < t % 3; h++) begin
        rsp_valid = (h == 0); rsp_data = 8'hEE;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R8 held valid", cyc_valid, 1);
        chk("R8 held addr", cyc_addr, a);
        chk("R8 stray pc", pc_o, m_pc);
        chk("R8 stray acc", acc_o, m_a);
      end
      cyc_ready = 1'b1;
      @(negedge clk);
      cyc_ready = 1'b0;
      chk("R8 no new req", cyc_valid, 0);
      for (int l = 0; l < t % 4; l++) begin
        @(negedge clk);
        chk("R8 wait", cyc_valid, 0);
      end
      d = (k == 2'b10) ? 0 : rd(a);
      if (k == 2'b10) mem[a] = w;
      rsp_valid = 1'b1; rsp_data = d[7:0];
      @(negedge clk);
      rsp_valid = 1'b0;
      case (m_ph)
        0: begin
          m_pc = (m_pc + 1) & 16'hFFFF;
          if (d == 8'h3E) m_ph = 1;
          else if (d == 8'h32) m_ph = 2;
          else if (d == 8'h4F) m_c = m_a;
        end
        1: begin m_a = d; m_pc = (m_pc + 1) & 16'hFFFF; m_ph = 0; end
        2: begin m_lo = d; m_pc = (m_pc + 1) & 16'hFFFF; m_ph = 3; end
        3: begin m_hi = d; m_pc = (m_pc + 1) & 16'hFFFF; m_ph = 4; end
        default: m_ph = 0;
      endcase
      chk("R7 pc", pc_o, m_pc);
      chk("R3 acc", acc_o, m_a);
      chk("R5 R6 regc", regc_o, m_c);
    end
    chk("R4 store 2065", rd(16'h2065), 8'h5A);
    chk("R4 store 03FF", rd(16'h03FF), 8'hA5);
    chk("R4 store 0000", rd(0), 8'h00);
    chk("R5 final regc", regc_o, 8'h00);
    done = 1'b1;
    summary();
  end
endmodule